// File: doc/BRIEF.md
# Pixel-Pattern Triggered Capture Scope

This block sits beside a calorimeter cluster trigger and watches the same data without ever holding it up or changing it. Each clock it takes one sample: a vector of per-pixel hit bits plus the current cluster count. A programmable trigger looks for a geometric arrangement of pixels, in which each pixel may be required to be hit, required to be quiet, or left out. This pattern may be combined with a minimum cluster count.

Samples are written into a circular buffer. After an arm pulse, the unit first collects a programmable amount of history. It then waits for the trigger, records a programmable number of samples after it, and freezes. A done flag then goes high. Software pulls the frozen window out through a simple read port, oldest sample first. Each returned sample carries a signed offset that gives its position relative to the trigger sample.

Top module: `pixel_scope`

## Requirements
- R1: A pixel with its `careMask` bit at 0 is ignored. A pixel with `careMask` 1 must equal its `wantMask` bit (1 = hit required, 0 = no hit required). The pattern matches only when every cared pixel agrees.
- R2: `trigMode` selects the trigger: 0 = pattern alone, 1 = count alone, 2 or 3 = pattern and count together. A condition that the mode does not use has no effect.
- R3: The count condition holds when `clusterCnt` >= `countMin`, and equality is enough.
- R4: Sampling starts on the clock after the edge that sees `arm` high. The first `preDepth` samples after arming are always stored, and a trigger condition in any of them is ignored.
- R5: The first qualifying sample after the history has filled is the trigger sample. Exactly `postDepth` further samples are then stored, and `done` goes high on the edge that stores the last of them (with `postDepth` = 0, on the edge that stores the trigger sample).
- R6: Once `done` is high, the buffer and `done` stay frozen whatever the inputs do, until the next `arm`. `arm` clears `done` and restarts capture.
- R7: While `done` is high, each cycle with `rdReq` high returns one sample on the next clock. The sample appears on `rdData` as {cluster count, hit bits}, with `rdValid` high. Samples come oldest first, `preDepth + postDepth + 1` of them.
- R8: `rdOffset` is the signed position of the returned sample relative to the trigger sample: `-preDepth` for the first sample, 0 for the trigger, `+postDepth` for the last.
- R9: `rdReq` has no effect while `done` is low, or once the whole window has been read. In both cases `rdValid` stays low.
- R10: Correct windows for the depth limits, from 0/0 up to 63/63, including windows that wrap around the buffer.
- R11: After reset, `done` and `rdValid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rstN | input | 1 | Active-low synchronous reset |
| arm | input | 1 | Start a new capture |
| hitVec | input | NUM_PIXELS | Per-pixel hit bits for this clock |
| clusterCnt | input | CNT_W | Cluster count for this clock |
| careMask | input | NUM_PIXELS | 1 = pixel takes part in the pattern |
| wantMask | input | NUM_PIXELS | Required pixel state where cared |
| trigMode | input | 2 | Trigger source select |
| countMin | input | CNT_W | Minimum cluster count |
| preDepth | input | PTR_W | Samples kept before the trigger |
| postDepth | input | PTR_W | Samples kept after the trigger |
| done | output | 1 | Capture frozen and readable |
| rdReq | input | 1 | Request next stored sample |
| rdValid | output | 1 | `rdData`/`rdOffset` valid |
| rdData | output | CNT_W+NUM_PIXELS | Stored sample {count, hits} |
| rdOffset | output | PTR_W+2 | Signed position relative to trigger |

## Verification
A wrong write pointer or a mis-counted window shows up at the ports as soon as the window is read back. The sample contents shift against their offsets, or the trigger sample does not sit at offset 0. A control counter that is off by one moves the rising edge of `done` by a cycle, which is visible on the exact clock where it should rise. A trigger taken during the history fill produces a window with too little pre-trigger history. It is seen at the first readback entry.

// File: rtl/scope_pkg.sv
package scope_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FILL,
    ST_WAIT,
    ST_POST,
    ST_DONE
  } scopeState_t;

  typedef struct packed {
    logic wrEn;
    logic rdEn;
    logic rdClear;
  } scopeStrb_t;

  localparam logic [1:0] MODE_PATTERN = 2'd0;
  localparam logic [1:0] MODE_COUNT   = 2'd1;

endpackage

// File: rtl/scope_match.sv
module scope_match #(
  parameter int NUM_PIXELS = 16,
  parameter int CNT_W      = 4
) (
  input  logic [NUM_PIXELS-1:0] hitVec,
  input  logic [CNT_W-1:0]      clusterCnt,
  input  logic [NUM_PIXELS-1:0] careMask,
  input  logic [NUM_PIXELS-1:0] wantMask,
  input  logic [1:0]            trigMode,
  input  logic [CNT_W-1:0]      countMin,
  output logic                  trigHit
);
  import scope_pkg::*;

  logic [NUM_PIXELS-1:0] pixOk;
  logic patOk;
  logic cntOk;

  for (genvar p = 0; p < NUM_PIXELS; p++) begin : g_pix
    assign pixOk[p] = !careMask[p] || (hitVec[p] == wantMask[p]);
  end

  assign patOk = &pixOk;
  assign cntOk = (clusterCnt >= countMin);

  always_comb begin
    unique case (trigMode)
      MODE_PATTERN: trigHit = patOk;
      MODE_COUNT:   trigHit = cntOk;
      default:      trigHit = patOk && cntOk;
    endcase
  end

endmodule

// File: rtl/scope_ctrl.sv
module scope_ctrl #(
  parameter int PTR_W = 6
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 arm,
  input  logic                 trigHit,
  input  logic [PTR_W-1:0]     preDepth,
  input  logic [PTR_W-1:0]     postDepth,
  input  logic                 rdReq,
  input  logic                 rdAvail,
  output scope_pkg::scopeStrb_t strb,
  output logic                 done
);
  import scope_pkg::*;

  scopeState_t state;
  logic [PTR_W-1:0] cnt;
  logic [PTR_W:0]   cntNext;

  assign cntNext = {1'b0, cnt} + 1'b1;

  always_comb begin
    strb.wrEn    = (state == ST_FILL) || (state == ST_WAIT) || (state == ST_POST);
    strb.rdEn    = (state == ST_DONE) && rdReq && rdAvail;
    strb.rdClear = arm;
  end

  assign done = (state == ST_DONE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else if (arm) begin
      cnt   <= '0;
      state <= (preDepth == '0) ? ST_WAIT : ST_FILL;
    end else begin
      unique case (state)
        ST_FILL: begin
          cnt <= cntNext[PTR_W-1:0];
          if (cntNext == {1'b0, preDepth}) begin
            state <= ST_WAIT;
            cnt   <= '0;
          end
        end
        ST_WAIT: begin
          if (trigHit) begin
            cnt   <= '0;
            state <= (postDepth == '0) ? ST_DONE : ST_POST;
          end
        end
        ST_POST: begin
          cnt <= cntNext[PTR_W-1:0];
          if (cntNext == {1'b0, postDepth}) state <= ST_DONE;
        end
        default: ;
      endcase
    end
  end

  AST_FILL_NO_TRIGGER: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_FILL) |=> (state == ST_FILL) || (state == ST_WAIT)); // R4
  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DONE) && !arm |=> (state == ST_DONE)); // R6
  AST_POST_FROM_WAIT: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_POST) && ($past(state) != ST_POST) |-> ($past(state) == ST_WAIT)); // R5

endmodule

// File: rtl/scope_data.sv
module scope_data #(
  parameter int NUM_PIXELS = 16,
  parameter int CNT_W      = 4,
  parameter int PTR_W      = 6
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  scope_pkg::scopeStrb_t       strb,
  input  logic [NUM_PIXELS-1:0]       hitVec,
  input  logic [CNT_W-1:0]            clusterCnt,
  input  logic [PTR_W-1:0]            preDepth,
  input  logic [PTR_W-1:0]            postDepth,
  output logic                        rdAvail,
  output logic                        rdValid,
  output logic [CNT_W+NUM_PIXELS-1:0] rdData,
  output logic signed [PTR_W+1:0]     rdOffset
);
  localparam int ADDR_W   = PTR_W + 1;
  localparam int DEPTH    = 1 << ADDR_W;
  localparam int SAMPLE_W = CNT_W + NUM_PIXELS;

  logic [SAMPLE_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] wrPtr;
  logic [ADDR_W-1:0] rdCnt;
  logic [ADDR_W-1:0] total;
  logic [ADDR_W-1:0] rdAddr;

  assign total   = {1'b0, preDepth} + {1'b0, postDepth} + 1'b1;
  assign rdAvail = (rdCnt < total);
  assign rdAddr  = wrPtr - total + rdCnt;

  always_ff @(posedge clk) begin
    if (strb.wrEn) mem[wrPtr] <= {clusterCnt, hitVec};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr    <= '0;
      rdCnt    <= '0;
      rdValid  <= 1'b0;
      rdData   <= '0;
      rdOffset <= '0;
    end else begin
      if (strb.wrEn) wrPtr <= wrPtr + 1'b1;
      rdValid <= strb.rdEn;
      if (strb.rdClear) begin
        rdCnt <= '0;
      end else if (strb.rdEn) begin
        rdData   <= mem[rdAddr];
        rdOffset <= $signed({1'b0, rdCnt}) - $signed({2'b0, preDepth});
        rdCnt    <= rdCnt + 1'b1;
      end
    end
  end

  AST_PTR_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrEn |=> $stable(wrPtr)); // R6
  AST_OFFSET_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> (rdOffset <= $signed({2'b0, postDepth}))
             && (rdOffset + $signed({2'b0, preDepth}) >= 0)); // R8
  AST_READ_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    rdCnt <= total || $past(strb.rdClear) || !$stable(total)); // R9

endmodule

// File: rtl/pixel_scope.sv
module pixel_scope #(
  parameter int NUM_PIXELS = 16,
  parameter int CNT_W      = 4,
  parameter int PTR_W      = 6
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        arm,
  input  logic [NUM_PIXELS-1:0]       hitVec,
  input  logic [CNT_W-1:0]            clusterCnt,
  input  logic [NUM_PIXELS-1:0]       careMask,
  input  logic [NUM_PIXELS-1:0]       wantMask,
  input  logic [1:0]                  trigMode,
  input  logic [CNT_W-1:0]            countMin,
  input  logic [PTR_W-1:0]            preDepth,
  input  logic [PTR_W-1:0]            postDepth,
  output logic                        done,
  input  logic                        rdReq,
  output logic                        rdValid,
  output logic [CNT_W+NUM_PIXELS-1:0] rdData,
  output logic signed [PTR_W+1:0]     rdOffset
);
  import scope_pkg::*;

  scopeStrb_t strb;
  logic trigHit;
  logic rdAvail;

  scope_match #(.NUM_PIXELS(NUM_PIXELS), .CNT_W(CNT_W)) i_match (
    .hitVec(hitVec), .clusterCnt(clusterCnt), .careMask(careMask),
    .wantMask(wantMask), .trigMode(trigMode), .countMin(countMin),
    .trigHit(trigHit)
  );

  scope_ctrl #(.PTR_W(PTR_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .arm(arm), .trigHit(trigHit),
    .preDepth(preDepth), .postDepth(postDepth), .rdReq(rdReq),
    .rdAvail(rdAvail), .strb(strb), .done(done)
  );

  scope_data #(.NUM_PIXELS(NUM_PIXELS), .CNT_W(CNT_W), .PTR_W(PTR_W)) i_data (
    .clk(clk), .rstN(rstN), .strb(strb), .hitVec(hitVec),
    .clusterCnt(clusterCnt), .preDepth(preDepth), .postDepth(postDepth),
    .rdAvail(rdAvail), .rdValid(rdValid), .rdData(rdData), .rdOffset(rdOffset)
  );

  AST_READ_AFTER_DONE: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> $past(done)); // R9

endmodule

// File: tb/test_pixel_scope.sv
module test_pixel_scope;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic arm = 1'b0;
  logic [15:0] hitVec = '0;
  logic [3:0]  clusterCnt = '0;
  logic [15:0] careMask = '0;
  logic [15:0] wantMask = '0;
  logic [1:0]  trigMode = '0;
  logic [3:0]  countMin = '0;
  logic [5:0]  preDepth = '0;
  logic [5:0]  postDepth = '0;
  logic        done;
  logic        rdReq = 1'b0;
  logic        rdValid;
  logic [19:0] rdData;
  logic signed [7:0] rdOffset;

  int nChecks = 0;
  int nFail = 0;
  logic [15:0] sHit [0:511];
  logic [3:0]  sCnt [0:511];

  always #2 clk = ~clk;

  pixel_scope i_pixel_scope (
    .clk(clk), .rstN(rstN), .arm(arm), .hitVec(hitVec), .clusterCnt(clusterCnt),
    .careMask(careMask), .wantMask(wantMask), .trigMode(trigMode),
    .countMin(countMin), .preDepth(preDepth), .postDepth(postDepth),
    .done(done), .rdReq(rdReq), .rdValid(rdValid), .rdData(rdData),
    .rdOffset(rdOffset)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic fillQuiet(input int n);
    for (int i = 0; i < n; i++) begin
      sHit[i] = {8'h00, 8'(i)};
      sCnt[i] = 4'd0;
    end
  endtask

  // Arms, streams samples, checks done timing, freeze and full readback.
  task automatic runCapture(input int pre, input int post, input int nS,
                            input int expTrig, input string tag);
    int doneBad = 0;
    int earlyRd = 0;
    int dataBad = 0;
    int offBad = 0;
    int total = pre + post + 1;
    int firstOff = 99;
    preDepth = 6'(pre);
    postDepth = 6'(post);
    arm = 1'b1;
    @(negedge clk);
    arm = 1'b0;
    check(done == 1'b0, "R6", {tag, " done cleared by arm"}, done, 0);
    rdReq = 1'b1; // R9: ignored while capturing
    for (int i = 0; i < nS; i++) begin
      hitVec = sHit[i];
      clusterCnt = sCnt[i];
      @(negedge clk);
      if (rdValid) earlyRd++;
      if (done !== (i >= expTrig + post)) doneBad++;
      if (done) break;
    end
    rdReq = 1'b0;
    check(doneBad == 0 && done, "R5", {tag, " done timing mismatches"}, doneBad, 0);
    check(earlyRd == 0, "R9", {tag, " rdValid before done"}, earlyRd, 0);
    // R6: frozen against further qualifying samples
    for (int i = 0; i < 6; i++) begin
      hitVec = 16'hFFFF ^ 16'(i);
      clusterCnt = 4'hF;
      @(negedge clk);
    end
    check(done == 1'b1, "R6", {tag, " done held"}, done, 1);
    rdReq = 1'b1;
    for (int j = 0; j < total; j++) begin
      int e = expTrig - pre + j;
      @(negedge clk);
      if (!rdValid || rdData !== {sCnt[e], sHit[e]}) dataBad++;
      if (int'(rdOffset) != j - pre) offBad++;
      if (j == 0) firstOff = int'(rdOffset);
    end
    check(dataBad == 0, "R7", {tag, " readback data errors"}, dataBad, 0);
    check(offBad == 0, "R8", {tag, " offset errors"}, offBad, 0);
    check(firstOff == -pre, "R8", {tag, " first offset"}, firstOff, -pre);
    @(negedge clk);
    check(rdValid == 1'b0, "R9", {tag, " read past window"}, rdValid, 0);
    rdReq = 1'b0;
    @(negedge clk);
  endtask

  task automatic testPattern();
    // R1 and R2 mode 0: care FF00, want A500; low byte don't care
    careMask = 16'hFF00; wantMask = 16'hA500; trigMode = 2'd0; countMin = 4'd1;
    fillQuiet(40);
    sHit[1] = 16'hA511;         // R4: during history fill, ignored
    sHit[3] = 16'hA533;         // R4: last fill sample, ignored
    sCnt[5] = 4'hF;             // R2: count unused in pattern mode
    sHit[6] = 16'hA700;         // R1: pixel required quiet is hit
    sHit[8] = 16'hA400;         // R1: pixel required hit is quiet
    sHit[10] = 16'hA5C3;        // trigger, don't-care bits set
    runCapture(4, 3, 40, 10, "pattern");
  endtask

  task automatic testCountOnly();
    // R2 mode 1, R3 >=, R10 zero depths
    careMask = 16'hFF00; wantMask = 16'hA500; trigMode = 2'd1; countMin = 4'd3;
    fillQuiet(20);
    sCnt[0] = 4'd2;
    sHit[1] = 16'hA500; sCnt[1] = 4'd2;  // pattern ignored in count mode
    sCnt[2] = 4'd5;
    runCapture(0, 0, 20, 2, "count");
  endtask

  task automatic testBoth();
    // R2 mode 2, R3 equality boundary
    careMask = 16'h00F0; wantMask = 16'h0050; trigMode = 2'd2; countMin = 4'd2;
    fillQuiet(30);
    for (int i = 0; i < 30; i++) sHit[i] = {8'(i), 8'h0F};
    sHit[3] = 16'h0E5F; sCnt[3] = 4'd1;  // pattern only
    sCnt[4] = 4'd7;                      // count only
    sHit[6] = 16'h3C50; sCnt[6] = 4'd2;  // both, count equal to min
    runCapture(2, 5, 30, 6, "both");
  endtask

  task automatic testWrap();
    // R10 max depths with buffer wrap, mode 3 acts as both
    careMask = 16'hF000; wantMask = 16'h9000; trigMode = 2'd3; countMin = 4'd4;
    for (int i = 0; i < 400; i++) begin
      sHit[i] = 16'(i) & 16'h0FFF;
      sCnt[i] = 4'(i % 4);
    end
    sHit[250] = 16'h9123; sCnt[250] = 4'd1;
    sHit[300] = 16'h9ABC; sCnt[300] = 4'd9;
    runCapture(63, 63, 400, 300, "wrap");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(done == 1'b0, "R11", "done after reset", done, 0);
    check(rdValid == 1'b0, "R11", "rdValid after reset", rdValid, 0);
    testPattern();
    testCountOnly();
    testBoth();
    testWrap();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule